// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block runs read and write cycles on an external asynchronous static RAM that is 16 bits wide and has a 17-bit word address. The RAM has one active-low enable per byte lane and no shared chip enable. It also has an active-low write strobe and an active-low output enable. On the host side the block takes a request with an address, a direction, write data and a per-lane byte mask, and it answers with a one-cycle ready pulse. When a read completes, the read data is returned together with that pulse.

Every strobe edge is placed by a clock-counted interval. The intervals are the address setup before the write strobe, the write pulse width, the recovery time after a write, the access time of a read, and the bus turnaround after a read. Each interval is a parameter in picoseconds and is rounded up to whole clocks, with a minimum of one clock. The defaults assume a 100 MHz clock and a 70 ns RAM, which gives these counts:

| Interval | Clocks |
|---|---|
| Setup | 1 |
| Write pulse | 6 |
| Write recovery | 2 |
| Read access | 7 |
| Read turnaround | 3 |

The controller drives the shared data bus only inside a write.

States:

| State | Meaning |
|---|---|
| ST_IDLE | Waiting for a request |
| ST_WSETUP | Address and lane enables applied |
| ST_WPULSE | Write strobe low, bus driven |
| ST_WREC | All strobes high, bus driven for the first clock only |
| ST_RACC | Output enable and lane enables low |
| ST_RREC | All strobes high while the RAM releases the bus |

Transitions:

| From | Condition | To |
|---|---|---|
| ST_IDLE | Write with a non-zero mask | ST_WSETUP |
| ST_IDLE | Read with a non-zero mask | ST_RACC |
| ST_WSETUP | Interval expired | ST_WPULSE |
| ST_WPULSE | Interval expired | ST_WREC |
| ST_WREC | Interval expired | ST_IDLE (ready) |
| ST_RACC | Interval expired, data captured | ST_RREC |
| ST_RREC | Interval expired | ST_IDLE (ready) |

A request with an all-zero mask gets ready one clock later and stays in ST_IDLE.

Handshake: the host raises `req` with the request fields stable and holds them until it sees `rdy` high. A request is not accepted in the cycle in which `rdy` is high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, both lane enables, the write strobe and the output enable are high, `rdy` is low, and the controller does not drive `ram_dq`.
- R2: A request with `be` equal to 2'b00 raises `rdy` exactly one clock after acceptance, and no lane enable, write strobe or output enable goes low.
- R3: In a write, the address and the selected lane enables are applied exactly one clock (the setup count) before the write strobe falls. `ram_addr` holds the requested address and does not change while the write strobe is low.
- R4: The output enable is high in every cycle in which the write strobe is low.
- R5: The write strobe stays low for exactly 6 clocks, the larger of the pulse-width and data-valid counts. The lane enables rise in the same clock as the write strobe. `ram_dq` carries the write data from the first low clock until one clock after the strobe rises, and is released from the second clock after the rise.
- R6: After a write, all strobes stay high for the 2-clock recovery interval before `rdy`. A host that issues its next request right after `rdy` sees a gap of exactly 4 clocks before the next lane enable falls, and a write takes 10 clocks from request to `rdy`.
- R7: In a read, the output enable stays low with the write strobe high for exactly 7 clocks. `rdata` is captured on the last of those clocks and is valid with `rdy`, 11 clocks after the request.
- R8: Mask bit 1 selects the upper lane enable (`ram_lane_en_n[1]`, bits 15:8) and mask bit 0 selects the lower lane enable (`ram_lane_en_n[0]`, bits 7:0). In a read, a lane that is not selected returns zero in `rdata`.
- R9: A write with one mask bit set changes only that byte of the addressed word, and the other byte reads back unchanged.
- R10: After a read, all strobes stay high for 3 clocks before `rdy`. A back-to-back next request sees a gap of exactly 5 clocks before a lane enable falls.
- R11: `rdy` is high for exactly one clock per request, and a write with an all-zero mask leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid, held until `rdy` |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Byte mask, bit 1 = upper byte, bit 0 = lower byte |
| addr | input | 17 | Word address |
| wdata | input | 16 | Write data |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `rdy` |
| ram_addr | output | 17 | RAM word address |
| ram_lane_en_n | output | 2 | Active-low lane enables, bit 1 upper, bit 0 lower |
| ram_wr_n | output | 1 | Active-low write strobe |
| ram_rd_n | output | 1 | Active-low output enable |
| ram_dq | inout | 16 | Bidirectional RAM data bus |

## Verification
A wrong state or a wrong interval count shows at the RAM pins within the interval concerned. Such a fault changes a measured strobe width, setup count or idle gap, or the request-to-ready latency, by at least one clock on the very first transaction. A wrong latch of the mask or the data shows as a read-back mismatch on the next read of that word. The partial-byte write pairs and the masked reads expose a lane decode that is swapped or stuck, and bus-drive errors show as a wrong value or a non-released bus in the two clocks after the write strobe rises.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WREC,
        ST_RACC,
        ST_RREC
    } ctl_state_t;

    // Interval in picoseconds to whole clocks, rounded up, at least one.
    function automatic int clocks_for(input int t_ps, input int clk_ps);
        int n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/sram_ival_timer.sv
module sram_ival_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R3: a loaded count always reaches zero one step at a time
    a_r3_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt_q) != '0 && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sram_byte_lanes.sv
module sram_byte_lanes #(
    parameter int LANES = 2,
    localparam int DW = 8 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] sel,
    input  logic             active,
    input  logic             capture,
    input  logic [DW-1:0]    dq_in,
    output logic [LANES-1:0] en_n,
    output logic [DW-1:0]    rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign en_n[i] = !(active && sel[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[8*i +: 8] <= '0;
            end else if (capture) begin
                rdata[8*i +: 8] <= sel[i] ? dq_in[8*i +: 8] : 8'h00;
            end
        end
    end

    // R8: a lane never enables without being selected
    a_r8_lane_sel: assert property (@(posedge clk) disable iff (!rst_n)
        ((~en_n & ~sel) == '0));
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int AW       = 17,
    parameter int LANES    = 2,
    parameter int CLK_PS   = 10000,
    parameter int T_AS_PS  = 0,
    parameter int T_WP_PS  = 55000,
    parameter int T_DW_PS  = 30000,
    parameter int T_WR_PS  = 15000,
    parameter int T_ACC_PS = 70000,
    parameter int T_OE_PS  = 35000,
    parameter int T_HZ_PS  = 25000,
    parameter int TW       = 16,
    localparam int DW      = 8 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [LANES-1:0] be,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic             rdy,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    ram_addr,
    output logic [LANES-1:0] ram_lane_en_n,
    output logic             ram_wr_n,
    output logic             ram_rd_n,
    inout  wire  [DW-1:0]    ram_dq
);
    localparam int N_AS  = clocks_for(T_AS_PS, CLK_PS);
    localparam int N_WP  = clocks_for((T_WP_PS > T_DW_PS) ? T_WP_PS : T_DW_PS, CLK_PS);
    localparam int N_WR  = clocks_for(T_WR_PS, CLK_PS);
    localparam int N_ACC = clocks_for((T_ACC_PS > T_OE_PS) ? T_ACC_PS : T_OE_PS, CLK_PS);
    localparam int N_HZ  = clocks_for(T_HZ_PS, CLK_PS);
    localparam int N_GAP = (N_WR < N_HZ) ? N_WR : N_HZ;

    ctl_state_t state_q, state_d;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [LANES-1:0] be_q;
    logic             rdy_q, tail_q;
    logic             t_load, t_done;
    logic [TW-1:0]    t_val;
    logic             accept, zero_req;
    logic             lanes_active, capture, drive;

    assign accept   = (state_q == ST_IDLE) && req && !rdy_q && (be != '0);
    assign zero_req = (state_q == ST_IDLE) && req && !rdy_q && (be == '0);

    // Next state and interval load
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = wr ? ST_WSETUP : ST_RACC;
            ST_WSETUP: if (t_done) state_d = ST_WPULSE;
            ST_WPULSE: if (t_done) state_d = ST_WREC;
            ST_WREC:   if (t_done) state_d = ST_IDLE;
            ST_RACC:   if (t_done) state_d = ST_RREC;
            ST_RREC:   if (t_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        t_load = (state_d != state_q);
        unique case (state_d)
            ST_WSETUP: t_val = TW'(N_AS - 1);
            ST_WPULSE: t_val = TW'(N_WP - 1);
            ST_WREC:   t_val = TW'(N_WR - 1);
            ST_RACC:   t_val = TW'(N_ACC - 1);
            ST_RREC:   t_val = TW'(N_HZ - 1);
            default:   t_val = '0;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdy_q   <= 1'b0;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rdy_q   <= zero_req ||
                       (((state_q == ST_WREC) || (state_q == ST_RREC)) && t_done);
            tail_q  <= (state_q == ST_WPULSE);
            if (accept) begin
                addr_q  <= addr;
                wdata_q <= wdata;
                be_q    <= be;
            end
        end
    end

    // Strobe and bus outputs decoded from state
    always_comb begin
        lanes_active = 1'b0;
        ram_wr_n     = 1'b1;
        ram_rd_n     = 1'b1;
        drive        = 1'b0;
        capture      = 1'b0;
        unique case (state_q)
            ST_WSETUP: lanes_active = 1'b1;
            ST_WPULSE: begin
                lanes_active = 1'b1;
                ram_wr_n     = 1'b0;
                drive        = 1'b1;
            end
            ST_WREC:   drive = tail_q;
            ST_RACC: begin
                lanes_active = 1'b1;
                ram_rd_n     = 1'b0;
                capture      = t_done;
            end
            default: ;
        endcase
    end

    assign ram_addr = addr_q;
    assign rdy      = rdy_q;
    assign ram_dq   = drive ? wdata_q : {DW{1'bz}};

    sram_ival_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_byte_lanes #(.LANES(LANES)) lanes_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (be_q),
        .active  (lanes_active),
        .capture (capture),
        .dq_in   (ram_dq),
        .en_n    (ram_lane_en_n),
        .rdata   (rdata)
    );

    // Checker state: strobe-low length and quiet time between accesses
    logic [TW-1:0] wl_cnt, quiet_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_cnt    <= '0;
            quiet_cnt <= '1;
        end else begin
            wl_cnt <= ram_wr_n ? '0 : wl_cnt + 1'b1;
            if (!(&ram_lane_en_n)) quiet_cnt <= '0;
            else if (quiet_cnt != '1) quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_n |-> ram_rd_n);

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_wr_n && !$past(ram_wr_n)) |-> $stable(ram_addr));

    a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_n) |-> (wl_cnt == TW'(N_WP)));

    a_r5_lanes_rise_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_n) |-> (&ram_lane_en_n));

    a_r6_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&ram_lane_en_n) && !(&ram_lane_en_n)) |-> (quiet_cnt >= TW'(N_GAP)));

    a_r2_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (rdy && (&ram_lane_en_n) && ram_wr_n && ram_rd_n));

    a_r11_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);
endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [1:0]  be = '0;
    logic [16:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        rdy;
    logic [15:0] rdata;
    logic [16:0] ram_addr;
    logic [1:0]  ram_lane_en_n;
    logic        ram_wr_n, ram_rd_n;
    wire  [15:0] dq_bus;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    sram_lane_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .be(be), .addr(addr),
        .wdata(wdata), .rdy(rdy), .rdata(rdata), .ram_addr(ram_addr),
        .ram_lane_en_n(ram_lane_en_n), .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n),
        .ram_dq(dq_bus)
    );

    // Small RAM model indexed by the low address byte
    logic [15:0] mem [256];
    assign dq_bus[15:8] = (!ram_lane_en_n[1] && !ram_rd_n && ram_wr_n) ? mem[ram_addr[7:0]][15:8] : 8'hzz;
    assign dq_bus[7:0]  = (!ram_lane_en_n[0] && !ram_rd_n && ram_wr_n) ? mem[ram_addr[7:0]][7:0]  : 8'hzz;
    always @(ram_wr_n, ram_lane_en_n, ram_addr, dq_bus) begin
        if (!ram_wr_n && !ram_lane_en_n[1]) mem[ram_addr[7:0]][15:8] = dq_bus[15:8];
        if (!ram_wr_n && !ram_lane_en_n[0]) mem[ram_addr[7:0]][7:0]  = dq_bus[7:0];
    end

    // Pin monitor, sampled on the falling edge
    int wl = 0, last_wp = 0, su = 0, last_su = 0, rl = 0, last_rd = 0;
    int gap = 0, last_gap = 0, cont_err = 0, addr_err = 0, late_err = 0;
    int tail_ph = 0, strobe_seen = 0;
    logic [15:0] tail1, tail2, exp_addr_lo;
    logic        prev_we = 1'b1, prev_oe = 1'b1, prev_quiet = 1'b1;
    logic [16:0] exp_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_wr_n && !ram_rd_n) cont_err++;
            if (!ram_wr_n && ram_addr !== exp_addr) addr_err++;
            if (!(&ram_lane_en_n) || !ram_wr_n || !ram_rd_n) strobe_seen++;
            if (!ram_wr_n) wl++;
            if (ram_wr_n && !prev_we) begin
                last_wp = wl; wl = 0;
                if (!(&ram_lane_en_n)) late_err++;
                tail1 = dq_bus; tail_ph = 1;
            end else if (tail_ph == 1) begin
                tail2 = dq_bus; tail_ph = 0;
            end
            if (!(&ram_lane_en_n) && ram_wr_n && ram_rd_n) su++;
            if (!ram_wr_n && prev_we) begin last_su = su; su = 0; end
            if (&ram_lane_en_n) su = 0;
            if (!ram_rd_n) rl++;
            if (ram_rd_n && !prev_oe) begin last_rd = rl; rl = 0; end
            if (&ram_lane_en_n) gap++;
            if (!(&ram_lane_en_n) && prev_quiet) begin last_gap = gap; gap = 0; end
            prev_we = ram_wr_n; prev_oe = ram_rd_n; prev_quiet = &ram_lane_en_n;
        end
    end

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_req(input logic w, input logic [1:0] m, input logic [16:0] a,
                          input logic [15:0] d, output logic [15:0] rd, output int lat);
        exp_addr = a;
        wr = w; be = m; addr = a; wdata = d; req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rdy && lat < 100);
        rd = rdata;
        req = 1'b0;
        @(negedge clk);
        check("R11 rdy single cycle", rdy, 0);
    endtask

    // {wr, be, addr, wdata, expected read}
    localparam logic [51:0] VEC [12] = '{
        {1'b1, 2'b11, 17'h00010, 16'hA5C3, 16'h0000},
        {1'b0, 2'b11, 17'h00010, 16'h0000, 16'hA5C3},
        {1'b1, 2'b01, 17'h00010, 16'hFF11, 16'h0000},
        {1'b0, 2'b11, 17'h00010, 16'h0000, 16'hA511},
        {1'b1, 2'b10, 17'h00010, 16'h77EE, 16'h0000},
        {1'b0, 2'b11, 17'h00010, 16'h0000, 16'h7711},
        {1'b0, 2'b10, 17'h00010, 16'h0000, 16'h7700},
        {1'b0, 2'b01, 17'h00010, 16'h0000, 16'h0011},
        {1'b1, 2'b11, 17'h10022, 16'h1234, 16'h0000},
        {1'b0, 2'b11, 17'h10022, 16'h0000, 16'h1234},
        {1'b1, 2'b00, 17'h00010, 16'hDEAD, 16'h0000},
        {1'b0, 2'b11, 17'h00010, 16'h0000, 16'h7711}
    };

    logic done_flag = 1'b0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] rd;
        int lat, seen0;
        repeat (3) @(negedge clk);
        check("R1 lane enables in reset", ram_lane_en_n, 2'b11);
        check("R1 strobes in reset", {ram_wr_n, ram_rd_n}, 2'b11);
        check("R1 rdy in reset", rdy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 bus released after reset", (dq_bus === 16'hzzzz), 1);
        check("R1 strobes after reset", {ram_lane_en_n, ram_wr_n, ram_rd_n}, 4'hF);

        for (int i = 0; i < 12; i++) begin
            logic        w;
            logic [1:0]  m;
            logic [16:0] a;
            logic [15:0] d, e;
            {w, m, a, d, e} = VEC[i];
            seen0 = strobe_seen;
            do_req(w, m, a, d, rd, lat);
            if (m == 2'b00) begin
                check("R2 zero mask latency", lat, 1);
                check("R2 zero mask no strobes", strobe_seen - seen0, 0);
            end else if (w) begin
                check("R6 write latency", lat, 10);
                check("R5 write pulse clocks", last_wp, 6);
                check("R3 setup clocks", last_su, 1);
                check("R5 bus driven one clock after rise", tail1, d);
                check("R5 bus released after tail", (tail2 === 16'hzzzz), 1);
            end else begin
                check("R7 read latency", lat, 11);
                check("R7 output enable clocks", last_rd, 7);
                check("R8 R9 R11 read data", rd, e);
            end
        end
        check("R3 address stable in write", addr_err, 0);
        check("R4 output enable high in write", cont_err, 0);
        check("R5 lanes rise with write strobe", late_err, 0);

        // Back-to-back gaps
        do_req(1'b1, 2'b11, 17'h00040, 16'h0F0F, rd, lat);
        do_req(1'b1, 2'b11, 17'h00041, 16'hF0F0, rd, lat);
        check("R6 gap after write", last_gap, 4);
        do_req(1'b0, 2'b11, 17'h00040, 16'h0000, rd, lat);
        check("R6 gap before read", last_gap, 4);
        check("R9 word intact", rd, 16'h0F0F);
        do_req(1'b1, 2'b01, 17'h00041, 16'h5A5A, rd, lat);
        check("R10 gap after read", last_gap, 5);
        do_req(1'b0, 2'b11, 17'h00041, 16'h0000, rd, lat);
        check("R9 lower-only write", rd, 16'hF05A);

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule